// File: doc/BRIEF.md
# Irreversible Logger Arming Sequencer

This block moves a battery-assisted data logger from its unarmed state to its armed state, exactly once. It watches the stream of memory-write events that a reader issues and waits for a 32-bit UTC timestamp to arrive in two 16-bit halves at a configured pair of consecutive words. The upper half must come first and the lower half second, and both writes must arrive while the logger runs in battery-assisted mode. The block also latches the first automatic battery measurement after power-up and compares it with a configured threshold.

The armed flag rises only when all of these hold together: the host has marked configuration complete, battery-assisted mode is active, the location configuration is well formed, a full timestamp has been committed, and the initial battery reading passed. The flag then stays set until the next power-on reset. After arming, the committed timestamp is frozen. The block keeps an initial-battery-alarm bit that a low first reading sets and that a reader can overwrite through an ordinary word write.

Top module: `logger_arm_seq`

## Requirements
- R1: After reset, `armed`, `utc_time` and `batt_alarm` are all zero.
- R2: A timestamp-half write counts only when `bap_mode` is 1 in the cycle it is sampled. Halves written with `bap_mode` at 0 neither commit `utc_time` nor enable arming.
- R3: The committed timestamp is `{high, low}`, where the high half is written to the base word and the low half is then written to base+1. `utc_time` updates in the cycle the low half is sampled. A low-half write that has no pending high half is ignored. A repeated high-half write replaces the pending high half.
- R4: While a high half is pending, any other write event, to any bank or address, discards the pending half.
- R5: The location is taken from `loc_hi` and `loc_lo`. Bits [15:10] of `loc_hi` must be zero and bits [9:8] must be 2'b10 (TID) or 2'b11 (User). Otherwise no write matches. The write-bus bank codes are 2'b00 reserved, 2'b01 EPC, 2'b10 TID and 2'b11 User. The base address is `{loc_hi[7:0], loc_lo}`, and base+1 carries across the 16-bit boundary.
- R6: Only the first `meas_valid` sample after reset is used. It passes only when `meas_value` is strictly greater than `meas_limit`.
- R7: `batt_alarm` is set when that first sample is strictly below `meas_limit`, and an equal value does not set it. A write to EPC (2'b01) word 0x21 loads data bit 11 into `batt_alarm`. A write to any other word leaves it unchanged.
- R8: `armed` rises on the clock edge after `cfg_done`, `bap_mode`, a valid location, a committed timestamp and a passed measurement first hold together, and not earlier.
- R9: Once set, `armed` stays 1 whatever the inputs do, until reset.
- R10: While armed, writes to the timestamp pair leave `utc_time` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_valid | input | 1 | Write event strobe |
| wr_bank | input | 2 | Bank of the write |
| wr_addr | input | 24 | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| bap_mode | input | 1 | Battery-assisted mode is active |
| cfg_done | input | 1 | Remaining logger configuration is complete |
| meas_valid | input | 1 | Battery measurement strobe |
| meas_value | input | 12 | Battery measurement value |
| meas_limit | input | 12 | Initial voltage threshold |
| loc_hi | input | 16 | Location word: zero bits, bank, address[23:16] |
| loc_lo | input | 16 | Location word: address[15:0] |
| armed | output | 1 | Sticky armed flag |
| utc_time | output | 32 | Committed timestamp |
| batt_alarm | output | 1 | Initial battery alarm |

## Verification
The bench targets the ordering corners. It writes the low half before the high half, sends a foreign write between the two halves, and rewrites the high half. A sequencer that tracked the halves loosely would commit a stale or mixed timestamp in these cases. It also writes the halves in passive mode and then switches to battery-assisted mode, which catches a design that remembers those writes. A measurement equal to the threshold must neither arm the logger nor raise the alarm, and a sloppy comparison would do one or the other. Other tests place the base at 0x..FFFF, where a missing carry puts the low half at the wrong word, and write, drop inputs and measure again after arming to expose a flag or timestamp that is not frozen.

// File: rtl/arm_seq_pkg.sv
package arm_seq_pkg;

  localparam int LOC_AW = 24;
  localparam int HALF_W = 16;

  localparam logic [1:0] BANK_RSV = 2'b00;
  localparam logic [1:0] BANK_EPC = 2'b01;
  localparam logic [1:0] BANK_TID = 2'b10;
  localparam logic [1:0] BANK_USR = 2'b11;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_HALF = 2'd1,
    TS_FULL = 2'd2
  } ts_state_e;

  // Location word is legal when the top six bits are clear and the bank is TID or User.
  function automatic logic loc_word_ok(input logic [15:0] hi);
    return (hi[15:10] == 6'd0) && (hi[9:8] == BANK_TID || hi[9:8] == BANK_USR);
  endfunction

  function automatic logic [LOC_AW-1:0] loc_base(input logic [15:0] hi, input logic [15:0] lo);
    return {hi[7:0], lo};
  endfunction

  function automatic logic [LOC_AW-1:0] loc_next(input logic [15:0] hi, input logic [15:0] lo);
    return loc_base(hi, lo) + LOC_AW'(1);
  endfunction

  function automatic logic volt_pass(input logic [15:0] v, input logic [15:0] th);
    return v > th;
  endfunction

  function automatic logic volt_low(input logic [15:0] v, input logic [15:0] th);
    return v < th;
  endfunction

endpackage

// File: rtl/arm_addr_match.sv
module arm_addr_match
  import arm_seq_pkg::*;
(
  input  logic [1:0]        wr_bank,
  input  logic [LOC_AW-1:0] wr_addr,
  input  logic [15:0]       loc_hi,
  input  logic [15:0]       loc_lo,
  output logic              loc_ok,
  output logic              hit_high,
  output logic              hit_low
);

  logic [LOC_AW-1:0] base_w;
  logic [LOC_AW-1:0] next_w;
  logic              bank_eq;

  always_comb begin
    loc_ok   = loc_word_ok(loc_hi);
    base_w   = loc_base(loc_hi, loc_lo);
    next_w   = loc_next(loc_hi, loc_lo);
    bank_eq  = (wr_bank == loc_hi[9:8]);
    hit_high = loc_ok && bank_eq && (wr_addr == base_w);
    hit_low  = loc_ok && bank_eq && (wr_addr == next_w);
  end

endmodule

// File: rtl/arm_ts_fsm.sv
module arm_ts_fsm
  import arm_seq_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic            bap_mode,
  input  logic            hit_high,
  input  logic            hit_low,
  input  logic            freeze,
  input  logic [HW-1:0]   wr_data,
  output logic            ts_done,
  output logic [2*HW-1:0] ts_word
);

  ts_state_e      state_q, state_d;
  logic [HW-1:0]  pend_q;
  logic           take_high;
  logic           take_low;
  logic           abandon;

  // Named events for the checks below.
  always_comb begin
    take_high = wr_valid && bap_mode && hit_high && !freeze;
    take_low  = wr_valid && bap_mode && hit_low && !freeze && (state_q == TS_HALF);
    abandon   = wr_valid && !freeze && (state_q == TS_HALF) && !take_high && !take_low;
  end

  always_comb begin
    state_d = state_q;
    if (take_high)      state_d = TS_HALF;
    else if (take_low)  state_d = TS_FULL;
    else if (abandon)   state_d = TS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      pend_q  <= '0;
      ts_word <= '0;
    end else begin
      state_q <= state_d;
      if (take_high) pend_q  <= wr_data;
      if (take_low)  ts_word <= {pend_q, wr_data};
    end
  end

  assign ts_done = (state_q == TS_FULL);

  a_r3_commit_follows_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ts_done) |-> $past(state_q == TS_HALF));

  a_r2_passive_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !bap_mode |=> $stable(ts_word));

  a_r4_abandon_drops: assert property (@(posedge clk) disable iff (!rst_n)
    abandon |=> (state_q == TS_IDLE));

  a_r10_frozen_pair: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(ts_word));

endmodule

// File: rtl/arm_batt_gate.sv
module arm_batt_gate
  import arm_seq_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_valid,
  input  logic [VW-1:0] meas_value,
  input  logic [VW-1:0] meas_limit,
  input  logic          alarm_wr,
  input  logic          alarm_bit,
  output logic          meas_pass,
  output logic          alarm
);

  logic meas_done;
  logic take;
  logic below;
  logic above;

  always_comb begin
    take  = meas_valid && !meas_done;
    above = volt_pass(16'(meas_value), 16'(meas_limit));
    below = volt_low(16'(meas_value), 16'(meas_limit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_done <= 1'b0;
      meas_pass <= 1'b0;
      alarm     <= 1'b0;
    end else begin
      if (take) begin
        meas_done <= 1'b1;
        meas_pass <= above;
      end
      if (take && below)  alarm <= 1'b1;
      else if (alarm_wr)  alarm <= alarm_bit;
    end
  end

  a_r6_pass_strict: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_pass) |-> $past(meas_valid && (meas_value > meas_limit)));

  a_r6_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> $stable(meas_pass));

  a_r7_low_sets_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (meas_value < meas_limit)) |=> alarm);

endmodule

// File: rtl/logger_arm_seq.sv
module logger_arm_seq
  import arm_seq_pkg::*;
#(
  parameter int               VW         = 12,
  parameter logic [LOC_AW-1:0] ALARM_WORD = 24'h000021,
  parameter int               ALARM_BIT  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        wr_bank,
  input  logic [LOC_AW-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              bap_mode,
  input  logic              cfg_done,
  input  logic              meas_valid,
  input  logic [VW-1:0]     meas_value,
  input  logic [VW-1:0]     meas_limit,
  input  logic [15:0]       loc_hi,
  input  logic [15:0]       loc_lo,
  output logic              armed,
  output logic [2*HALF_W-1:0] utc_time,
  output logic              batt_alarm
);

  logic loc_ok;
  logic hit_high;
  logic hit_low;
  logic ts_done;
  logic meas_pass;
  logic alarm_wr;
  logic arm_ready;
  logic armed_q;

  arm_addr_match u_match (
    .wr_bank  (wr_bank),
    .wr_addr  (wr_addr),
    .loc_hi   (loc_hi),
    .loc_lo   (loc_lo),
    .loc_ok   (loc_ok),
    .hit_high (hit_high),
    .hit_low  (hit_low)
  );

  arm_ts_fsm #(.HW(HALF_W)) u_ts (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .bap_mode (bap_mode),
    .hit_high (hit_high),
    .hit_low  (hit_low),
    .freeze   (armed_q),
    .wr_data  (wr_data),
    .ts_done  (ts_done),
    .ts_word  (utc_time)
  );

  assign alarm_wr = wr_valid && (wr_bank == BANK_EPC) && (wr_addr == ALARM_WORD);

  arm_batt_gate #(.VW(VW)) u_batt (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .meas_value (meas_value),
    .meas_limit (meas_limit),
    .alarm_wr   (alarm_wr),
    .alarm_bit  (wr_data[ALARM_BIT]),
    .meas_pass  (meas_pass),
    .alarm      (batt_alarm)
  );

  assign arm_ready = cfg_done && bap_mode && loc_ok && ts_done && meas_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (arm_ready) armed_q <= 1'b1;
  end

  assign armed = armed_q;

  a_r9_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  a_r8_arms_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ready |=> armed);

  a_r8_no_early_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(cfg_done && bap_mode && ts_done && meas_pass));

  a_r10_time_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(utc_time));

endmodule

// File: tb/logger_arm_seq_test.sv
module logger_arm_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_bank = 2'b00;
  logic [23:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        bap_mode = 1'b0;
  logic        cfg_done = 1'b0;
  logic        meas_valid = 1'b0;
  logic [11:0] meas_value = '0;
  logic [11:0] meas_limit = 12'd150;
  logic [15:0] loc_hi = 16'h0300;
  logic [15:0] loc_lo = 16'h0014;
  logic        armed;
  logic [31:0] utc_time;
  logic        batt_alarm;

  int checks = 0;
  int failures = 0;

  localparam logic [1:0] B_EPC = 2'b01;
  localparam logic [1:0] B_TID = 2'b10;
  localparam logic [1:0] B_USR = 2'b11;

  always #10 clk = ~clk;

  logger_arm_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .bap_mode(bap_mode), .cfg_done(cfg_done),
    .meas_valid(meas_valid), .meas_value(meas_value), .meas_limit(meas_limit),
    .loc_hi(loc_hi), .loc_lo(loc_lo), .armed(armed), .utc_time(utc_time),
    .batt_alarm(batt_alarm)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_valid = 1'b0; meas_valid = 1'b0;
    bap_mode = 1'b0; cfg_done = 1'b0;
    loc_hi = 16'h0300; loc_lo = 16'h0014; meas_limit = 12'd150;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic wr(input logic [1:0] b, input logic [23:0] a, input logic [15:0] d);
    wr_valid = 1'b1; wr_bank = b; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic meas(input logic [11:0] v);
    meas_valid = 1'b1; meas_value = v;
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "armed after reset", 32'(armed), 32'd0);
    chk("R1", "utc after reset", utc_time, 32'd0);
    chk("R1", "alarm after reset", 32'(batt_alarm), 32'd0);
  endtask

  task automatic t_happy_and_sticky();
    do_reset();
    bap_mode = 1'b1; cfg_done = 1'b1;
    meas(12'd200);
    wr(B_USR, 24'h14, 16'h6512);
    chk("R3", "utc before low half", utc_time, 32'd0);
    wr(B_USR, 24'h15, 16'hABCD);
    chk("R3", "utc after low half", utc_time, 32'h6512ABCD);
    chk("R8", "armed not yet", 32'(armed), 32'd0);
    idle(1);
    chk("R8", "armed one edge later", 32'(armed), 32'd1);
    chk("R7", "no alarm on good reading", 32'(batt_alarm), 32'd0);
    bap_mode = 1'b0; cfg_done = 1'b0;
    idle(3);
    chk("R9", "armed after inputs drop", 32'(armed), 32'd1);
    bap_mode = 1'b1;
    wr(B_USR, 24'h14, 16'h1111);
    wr(B_USR, 24'h15, 16'h2222);
    idle(1);
    chk("R10", "utc frozen while armed", utc_time, 32'h6512ABCD);
    meas(12'd50);
    chk("R6", "later low sample ignored", 32'(batt_alarm), 32'd0);
    chk("R9", "still armed", 32'(armed), 32'd1);
  endtask

  task automatic t_passive();
    do_reset();
    cfg_done = 1'b1; bap_mode = 1'b0;
    meas(12'd200);
    wr(B_USR, 24'h14, 16'h1234);
    wr(B_USR, 24'h15, 16'h5678);
    bap_mode = 1'b1;
    idle(2);
    chk("R2", "passive halves not committed", utc_time, 32'd0);
    chk("R2", "passive halves do not arm", 32'(armed), 32'd0);
    wr(B_USR, 24'h14, 16'h1234);
    wr(B_USR, 24'h15, 16'h5678);
    idle(1);
    chk("R2", "bap halves commit", utc_time, 32'h12345678);
    chk("R2", "bap halves arm", 32'(armed), 32'd1);
  endtask

  task automatic t_order();
    do_reset();
    bap_mode = 1'b1; cfg_done = 1'b1;
    meas(12'd200);
    wr(B_USR, 24'h15, 16'h2222);
    wr(B_USR, 24'h14, 16'h1111);
    idle(2);
    chk("R3", "low before high ignored", utc_time, 32'd0);
    chk("R3", "no arm on wrong order", 32'(armed), 32'd0);
    wr(B_TID, 24'h14, 16'h0000);
    wr(B_USR, 24'h15, 16'h3333);
    idle(1);
    chk("R4", "other bank write drops high", utc_time, 32'd0);
    wr(B_USR, 24'h14, 16'h4444);
    wr(B_USR, 24'h30, 16'h0000);
    wr(B_USR, 24'h15, 16'h5555);
    idle(1);
    chk("R4", "other address write drops high", utc_time, 32'd0);
    chk("R4", "not armed after drop", 32'(armed), 32'd0);
    wr(B_USR, 24'h14, 16'hAAAA);
    wr(B_USR, 24'h14, 16'hBBBB);
    wr(B_USR, 24'h15, 16'hCCCC);
    chk("R3", "rewritten high half used", utc_time, 32'hBBBBCCCC);
  endtask

  task automatic t_location();
    do_reset();
    bap_mode = 1'b1; cfg_done = 1'b1;
    meas(12'd200);
    loc_hi = 16'h0700;
    wr(B_USR, 24'h14, 16'h1111);
    wr(B_USR, 24'h15, 16'h2222);
    idle(2);
    chk("R5", "nonzero top bits reject", utc_time, 32'd0);
    chk("R5", "no arm with bad location", 32'(armed), 32'd0);
    loc_hi = 16'h0100;
    wr(B_EPC, 24'h14, 16'h1111);
    wr(B_EPC, 24'h15, 16'h2222);
    idle(2);
    chk("R5", "EPC bank field rejected", utc_time, 32'd0);
    loc_hi = 16'h0201; loc_lo = 16'hFFFF;
    wr(B_USR, 24'h01FFFF, 16'h1111);
    wr(B_USR, 24'h020000, 16'h2222);
    idle(1);
    chk("R5", "wrong write bank rejected", utc_time, 32'd0);
    wr(B_TID, 24'h01FFFF, 16'h1357);
    wr(B_TID, 24'h020000, 16'h2468);
    chk("R5", "carry into upper address", utc_time, 32'h13572468);
    idle(1);
    chk("R5", "arms with TID location", 32'(armed), 32'd1);
  endtask

  task automatic t_battery();
    do_reset();
    bap_mode = 1'b1; cfg_done = 1'b1;
    meas(12'd150);
    chk("R7", "equal reading no alarm", 32'(batt_alarm), 32'd0);
    wr(B_USR, 24'h14, 16'h0101);
    wr(B_USR, 24'h15, 16'h0202);
    idle(2);
    chk("R6", "equal reading does not arm", 32'(armed), 32'd0);
    meas(12'd300);
    idle(2);
    chk("R6", "second sample ignored", 32'(armed), 32'd0);
    do_reset();
    meas(12'd100);
    chk("R7", "low reading sets alarm", 32'(batt_alarm), 32'd1);
    wr(B_EPC, 24'h21, 16'h0000);
    chk("R7", "reader clears alarm", 32'(batt_alarm), 32'd0);
    wr(B_EPC, 24'h21, 16'h0800);
    chk("R7", "reader sets alarm", 32'(batt_alarm), 32'd1);
    wr(B_EPC, 24'h22, 16'h0000);
    chk("R7", "other word leaves alarm", 32'(batt_alarm), 32'd1);
  endtask

  task automatic t_arm_wait();
    do_reset();
    bap_mode = 1'b1; cfg_done = 1'b0;
    meas(12'd200);
    wr(B_USR, 24'h14, 16'h0F0F);
    wr(B_USR, 24'h15, 16'hF0F0);
    idle(3);
    chk("R8", "waits for cfg_done", 32'(armed), 32'd0);
    cfg_done = 1'b1;
    chk("R8", "not armed same cycle", 32'(armed), 32'd0);
    idle(1);
    chk("R8", "armed after cfg_done edge", 32'(armed), 32'd1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_happy_and_sticky();
    t_passive();
    t_order();
    t_location();
    t_battery();
    t_arm_wait();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule